// File: doc/BRIEF.md
# Infrared Run-Length Sampler

This block watches the single-bit output of an infrared demodulator and condenses it into a stream of byte-wide run-length codes. A prescaler divides the base clock into a sample tick. On each tick the synchronised line, optionally inverted, passes through a glitch filter that only accepts a new level once it has held for a programmable number of samples. A run tracker counts how many samples each accepted level lasts. When the level changes it hands one code downstream on a valid/ready push toward a receive FIFO.

A packet begins on the first pulse seen while the tracker is idle. A very long run is cut into full-length chunks. A space that outlasts a programmable idle window closes the packet: the last space code goes out together with a one-cycle packet-end strobe, and the tracker then stays silent until the next pulse. The FIFO is expected to be ready, because a code that meets a full FIFO is lost and reported on an overflow strobe. Threshold values and the enable come straight in on ports from the surrounding register logic.

Top module: `ir_rle_sampler`

## Requirements
- R1: One sample is taken every DIV_CYCLES base clock cycles (64 by default), and run lengths are counted in these samples.
- R2: Each code is a byte whose bit 7 holds the run level (1 = pulse, 0 = space) and whose bits 6:0 hold the run length in samples minus one; codes leave in the order the runs occurred.
- R3: When `invert` is high the line is inverted before sampling, so a low line is a pulse.
- R4: A line level that differs from the accepted level for at most `noise_thr` consecutive samples is ignored; one that differs for `noise_thr`+1 samples is accepted, and run lengths are measured between accepted changes.
- R5: A run longer than 128 samples is sent as codes with bits 6:0 = 127 for each full 128-sample chunk, then one code for the remainder; a run of exactly 128 samples gives a single code of 127.
- R6: When a space reaches (`idle_thr`+1)×128 samples, its last code (space level) is issued and `packet_end` is high in that same cycle as `code_valid`.
- R7: While no packet is open (after reset, enable or packet end) space samples produce no code; the next accepted pulse opens a new packet.
- R8: A code issued while `code_ready` is low is dropped and `overflow` pulses high for one cycle in the following cycle; otherwise `overflow` stays low.
- R9: While `enable` is low no code is issued, and the run count, idle count and last level are cleared, so a run in progress is discarded and space is assumed on re-enable.
- R10: After reset `code_valid`, `packet_end` and `overflow` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Receiver enable; low clears the sampler state |
| invert | input | 1 | Invert the line before sampling |
| noise_thr | input | 6 | Glitch rejection length in samples |
| idle_thr | input | 8 | Idle window, (value+1)×128 samples of space |
| ir_in | input | 1 | Demodulated infrared line, asynchronous |
| code_ready | input | 1 | FIFO can take a code this cycle |
| code_valid | output | 1 | One-cycle strobe carrying a code |
| code_data | output | 8 | Level in bit 7, length minus one in bits 6:0 |
| packet_end | output | 1 | Marks the code that closes a packet |
| overflow | output | 1 | A code was dropped for lack of ready |

## Verification
The assertions assume `noise_thr`, `idle_thr` and `invert` change only while no packet is open or while `enable` is low, since a polarity flip in mid-packet reads as an edge. They also assume `code_ready` does not change in the cycle a code is offered. The stimulus holds the line for whole multiples of the sample period. It changes the configuration only after a packet end or with the block disabled, and it moves `code_ready` only while the line is quiet.

// File: rtl/ir_rle_pkg.sv
package ir_rle_pkg;
  localparam int LEN_W = 7;
  localparam logic [LEN_W-1:0] LEN_MAX = {LEN_W{1'b1}};

  typedef struct packed {
    logic             level;
    logic [LEN_W-1:0] len_m1;
  } rle_code_t;
endpackage

// File: rtl/rle_prescaler.sv
module rle_prescaler #(
  parameter int DIV_CYCLES = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  output logic tick
);
  localparam int CW = (DIV_CYCLES > 1) ? $clog2(DIV_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(DIV_CYCLES - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          tick_d;

  always_comb begin
    cnt_d  = cnt_q;
    tick_d = 1'b0;
    if (!enable) begin
      cnt_d = '0;
    end else if (cnt_q == LAST) begin
      cnt_d  = '0;
      tick_d = 1'b1;
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      tick  <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      tick  <= tick_d;
    end
  end

  AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> !tick); // R1
  AST_TICK_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !tick); // R9
endmodule

// File: rtl/rle_level_filter.sv
module rle_level_filter #(
  parameter int NOISE_W = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable,
  input  logic               invert,
  input  logic [NOISE_W-1:0] noise_thr,
  input  logic               ir_in,
  input  logic               tick,
  output logic               level,
  output logic               level_tick
);
  logic [1:0]         sync_q;
  logic               raw;
  logic [NOISE_W-1:0] streak_q, streak_d;
  logic               level_d;

  assign raw = sync_q[1] ^ invert;

  always_comb begin
    streak_d = streak_q;
    level_d  = level;
    if (!enable) begin
      streak_d = '0;
      level_d  = 1'b0;
    end else if (tick) begin
      if (raw == level) begin
        streak_d = '0;
      end else if (streak_q >= noise_thr) begin
        streak_d = '0;
        level_d  = raw;
      end else begin
        streak_d = streak_q + 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q     <= '0;
      streak_q   <= '0;
      level      <= 1'b0;
      level_tick <= 1'b0;
    end else begin
      sync_q     <= {sync_q[0], ir_in};
      streak_q   <= streak_d;
      level      <= level_d;
      level_tick <= tick & enable;
    end
  end

  AST_LEVEL_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && $past(enable) && (level != $past(level))) |-> $past(tick)); // R4
  AST_FILTER_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !level); // R9
endmodule

// File: rtl/rle_run_tracker.sv
module rle_run_tracker
  import ir_rle_pkg::*;
#(
  parameter int IDLE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              level,
  input  logic              level_tick,
  input  logic [IDLE_W-1:0] idle_thr,
  output logic              emit_valid,
  output rle_code_t         emit_code,
  output logic              emit_last
);
  localparam int IW = IDLE_W + LEN_W;

  logic             active_q, active_d;
  logic             last_q, last_d;
  logic [LEN_W-1:0] run_q, run_d;
  logic [IW-1:0]    idle_q, idle_d;
  logic             vld_d, end_d;
  rle_code_t        code_d;
  logic [IW-1:0]    idle_limit;

  assign idle_limit = {idle_thr, LEN_MAX};

  always_comb begin
    active_d = active_q;
    last_d   = last_q;
    run_d    = run_q;
    idle_d   = idle_q;
    vld_d    = 1'b0;
    end_d    = 1'b0;
    code_d   = emit_code;
    if (!enable) begin
      active_d = 1'b0;
      last_d   = 1'b0;
      run_d    = '0;
      idle_d   = '0;
    end else if (level_tick) begin
      if (!active_q) begin
        if (level) begin
          active_d = 1'b1;
          last_d   = 1'b1;
          run_d    = '0;
          idle_d   = '0;
        end
      end else if (level != last_q) begin
        vld_d  = 1'b1;
        code_d = '{level: last_q, len_m1: run_q};
        last_d = level;
        run_d  = '0;
        idle_d = '0;
      end else begin
        if (run_q == LEN_MAX) begin
          vld_d  = 1'b1;
          code_d = '{level: last_q, len_m1: LEN_MAX};
          run_d  = '0;
        end else begin
          run_d = run_q + 1'b1;
        end
        if (!last_q) begin
          idle_d = idle_q + 1'b1;
          if (idle_d == idle_limit) begin
            vld_d    = 1'b1;
            end_d    = 1'b1;
            code_d   = '{level: 1'b0, len_m1: run_d};
            active_d = 1'b0;
            last_d   = 1'b0;
            run_d    = '0;
            idle_d   = '0;
          end
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q   <= 1'b0;
      last_q     <= 1'b0;
      run_q      <= '0;
      idle_q     <= '0;
      emit_valid <= 1'b0;
      emit_last  <= 1'b0;
      emit_code  <= '0;
    end else begin
      active_q   <= active_d;
      last_q     <= last_d;
      run_q      <= run_d;
      idle_q     <= idle_d;
      emit_valid <= vld_d;
      emit_last  <= end_d;
      emit_code  <= code_d;
    end
  end

  AST_END_IS_SPACE: assert property (@(posedge clk) disable iff (!rst_n)
    emit_last |-> (emit_valid && !emit_code.level)); // R6
  AST_DISABLED_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> !emit_valid); // R9
  AST_CODE_SPACING: assert property (@(posedge clk) disable iff (!rst_n)
    emit_valid |=> !emit_valid); // R5
  AST_IDLE_CLOSED: assert property (@(posedge clk) disable iff (!rst_n)
    emit_last |=> !active_q); // R7
endmodule

// File: rtl/ir_rle_sampler.sv
module ir_rle_sampler
  import ir_rle_pkg::*;
#(
  parameter int DIV_CYCLES = 64,
  parameter int NOISE_W    = 6,
  parameter int IDLE_W     = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               enable,
  input  logic               invert,
  input  logic [NOISE_W-1:0] noise_thr,
  input  logic [IDLE_W-1:0]  idle_thr,
  input  logic               ir_in,
  input  logic               code_ready,
  output logic               code_valid,
  output logic [LEN_W:0]     code_data,
  output logic               packet_end,
  output logic               overflow
);
  logic      tick;
  logic      level;
  logic      level_tick;
  rle_code_t code;
  logic      ovf_d;

  rle_prescaler #(.DIV_CYCLES(DIV_CYCLES)) u_presc (
    .clk    (clk),
    .rst_n  (rst_n),
    .enable (enable),
    .tick   (tick)
  );

  rle_level_filter #(.NOISE_W(NOISE_W)) u_filter (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .invert     (invert),
    .noise_thr  (noise_thr),
    .ir_in      (ir_in),
    .tick       (tick),
    .level      (level),
    .level_tick (level_tick)
  );

  rle_run_tracker #(.IDLE_W(IDLE_W)) u_tracker (
    .clk        (clk),
    .rst_n      (rst_n),
    .enable     (enable),
    .level      (level),
    .level_tick (level_tick),
    .idle_thr   (idle_thr),
    .emit_valid (code_valid),
    .emit_code  (code),
    .emit_last  (packet_end)
  );

  assign code_data = code;

  always_comb begin
    ovf_d = code_valid & ~code_ready;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      overflow <= 1'b0;
    end else begin
      overflow <= ovf_d;
    end
  end

  AST_OVF_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    (code_valid && !code_ready) |=> overflow); // R8
  AST_OVF_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    overflow |-> ($past(code_valid) && !$past(code_ready))); // R8
endmodule

// File: tb/tb_ir_rle_sampler.sv
module tb_ir_rle_sampler;
  localparam int SP = 64;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       enable = 1'b0;
  logic       invert = 1'b0;
  logic [5:0] noise_thr = '0;
  logic [7:0] idle_thr = '0;
  logic       ir_in = 1'b0;
  logic       code_ready = 1'b1;
  logic       code_valid;
  logic [7:0] code_data;
  logic       packet_end;
  logic       overflow;

  int checks = 0;
  int fails = 0;
  int ovf_cnt = 0;
  int pe_cnt = 0;
  bit done = 0;
  logic [8:0] got_q[$];
  logic [8:0] exp_q[$];

  // main table: {level, samples}
  localparam logic [16:0] RUNS [10] = '{
    {1'b1, 16'd5}, {1'b0, 16'd3}, {1'b1, 16'd1}, {1'b0, 16'd127},
    {1'b1, 16'd128}, {1'b0, 16'd10}, {1'b1, 16'd130}, {1'b0, 16'd2},
    {1'b1, 16'd7}, {1'b0, 16'd130}};

  always #2.5 clk = ~clk;

  ir_rle_sampler dut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .invert(invert),
    .noise_thr(noise_thr), .idle_thr(idle_thr), .ir_in(ir_in),
    .code_ready(code_ready), .code_valid(code_valid), .code_data(code_data),
    .packet_end(packet_end), .overflow(overflow));

  always @(negedge clk) begin
    if (rst_n) begin
      if (code_valid && code_ready) got_q.push_back({packet_end, code_data});
      if (overflow) ovf_cnt++;
      if (packet_end) pe_cnt++;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic hold(input logic v, input int n);
    @(negedge clk);
    ir_in = v;
    repeat (n * SP - 1) @(negedge clk);
  endtask

  // expected codes for one run, split into 128-sample chunks
  task automatic expect_run(input logic lvl, input int n, input bit pe);
    int left = n;
    while (left > 128) begin
      exp_q.push_back({1'b0, lvl, 7'h7f});
      left -= 128;
    end
    exp_q.push_back({pe, lvl, 7'(left - 1)});
  endtask

  task automatic compare(input string req);
    repeat (20) @(negedge clk);
    check(got_q.size() == exp_q.size(), {req, " count"}, got_q.size(), exp_q.size());
    for (int i = 0; i < exp_q.size() && i < got_q.size(); i++)
      check(got_q[i] == exp_q[i], req, got_q[i], exp_q[i]);
    got_q.delete();
    exp_q.delete();
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (5) @(negedge clk);
    // R10: reset state
    check(code_valid == 0, "R10 valid", code_valid, 0);
    check(packet_end == 0, "R10 packet_end", packet_end, 0);
    check(overflow == 0, "R10 overflow", overflow, 0);
    rst_n = 1'b1;
    @(negedge clk);
    enable = 1'b1;
    hold(1'b0, 4);

    // R1 R2 R5 R6 R7: table of runs, closing space at idle_thr=0
    for (int i = 0; i < 10; i++) begin
      hold(RUNS[i][16], int'(RUNS[i][15:0]));
      if (i < 9) expect_run(RUNS[i][16], int'(RUNS[i][15:0]), 1'b0);
    end
    exp_q.push_back({1'b1, 8'h7f});
    compare("R2 R5 R6 table");
    check(pe_cnt == 1, "R6 packet_end count", pe_cnt, 1);

    // R7: space after packet end gives nothing
    hold(1'b0, 40);
    compare("R7 silent idle");

    // R3: inverted line, low = pulse
    @(negedge clk); enable = 1'b0; invert = 1'b1; ir_in = 1'b1;
    @(negedge clk); enable = 1'b1;
    hold(1'b1, 3);
    hold(1'b0, 10);
    hold(1'b1, 130);
    exp_q.push_back({1'b0, 8'h89});
    exp_q.push_back({1'b1, 8'h7f});
    compare("R3 invert");
    @(negedge clk); enable = 1'b0; invert = 1'b0; ir_in = 1'b0;
    @(negedge clk); enable = 1'b1;

    // R4: glitch filter with noise_thr=2
    noise_thr = 6'd2;
    hold(1'b0, 3);
    hold(1'b1, 2);
    hold(1'b0, 20);
    compare("R4 leading glitch rejected");
    hold(1'b1, 3);
    hold(1'b0, 2);
    hold(1'b1, 4);
    hold(1'b0, 132);
    exp_q.push_back({1'b0, 8'h88});
    exp_q.push_back({1'b1, 8'h7f});
    compare("R4 space glitch merged");
    hold(1'b1, 3);
    hold(1'b0, 132);
    exp_q.push_back({1'b0, 8'h82});
    exp_q.push_back({1'b1, 8'h7f});
    compare("R4 threshold plus one accepted");
    noise_thr = 6'd0;

    // R6: idle_thr=1, packet closes after 256 space samples
    idle_thr = 8'd1;
    pe_cnt = 0;
    hold(1'b1, 2);
    hold(1'b0, 260);
    exp_q.push_back({1'b0, 8'h81});
    exp_q.push_back({1'b0, 8'h7f});
    exp_q.push_back({1'b1, 8'h7f});
    compare("R6 idle window 256");
    check(pe_cnt == 1, "R6 single packet_end", pe_cnt, 1);
    idle_thr = 8'd0;

    // R8: ready low drops codes and flags overflow
    check(ovf_cnt == 0, "R8 no overflow while ready", ovf_cnt, 0);
    @(negedge clk); code_ready = 1'b0;
    hold(1'b1, 4);
    hold(1'b0, 130);
    repeat (20) @(negedge clk);
    code_ready = 1'b1;
    compare("R8 dropped codes");
    check(ovf_cnt == 2, "R8 overflow count", ovf_cnt, 2);
    ovf_cnt = 0;

    // R9: disable discards a run in progress
    hold(1'b1, 20);
    @(negedge clk); enable = 1'b0;
    hold(1'b1, 30);
    @(negedge clk); ir_in = 1'b0;
    repeat (20) @(negedge clk);
    compare("R9 nothing while disabled");
    @(negedge clk); enable = 1'b1;
    hold(1'b0, 5);
    hold(1'b1, 6);
    hold(1'b0, 130);
    exp_q.push_back({1'b0, 8'h85});
    exp_q.push_back({1'b1, 8'h7f});
    compare("R9 fresh packet after enable");
    check(ovf_cnt == 0, "R8 R9 no stray overflow", ovf_cnt, 0);

    finish_run();
  end
endmodule